// File: doc/BRIEF.md
# Masked Burst Write Engine

This block takes a two-clock burst-write command from a host and then accepts one 68-bit word per clock into either a data array or a mask array of a search memory. The target address is not on the bus. It comes from an internal burst register holding a 15-bit start address and a burst length. The host loads that register beforehand, and the address steps by one for every word the device accepts. Each word is merged into the stored word through one of eight global mask registers. The command picks which one. Only bit positions where the mask holds a 1 take the new value.

A 5-bit device ID carried on the bus decides whether this device takes part. The all-ones ID addresses every device. A three-state end-of-transfer flag, modelled as a value plus an output enable, follows a fixed schedule that depends only on the burst length. The schedule runs even when the device is not selected, so bus timing does not change. A read port returns any stored word so the contents can be inspected.

Clock numbering used below: the two command clocks are 1A and 1B. The data clocks are 2 to n+1. The closing clock is n+2, where n is the stored burst length. A burst therefore occupies n+3 clocks.

Top module: `mbw_burst_write`

## Requirements
- R1: A burst starts only when two consecutive clocks (1A, 1B) each present cmd_valid_i=1, cmd_i[2]=1 and cmd_i[1:0]=2'b01. Mask index cmd_i[5:3], device ID dq_i[25:21] and array code dq_i[20:19] are captured in 1A only. If 1B does not repeat the command, the block returns to idle with no writes and no flag drive.
- R2: Each data word updates the stored word only in the bit positions where the selected global mask register holds 1. All other bits keep their old value.
- R3: The device is selected when dq_i[25:21] equals dev_id_i or equals 5'b11111. When it is not selected, no array changes and the burst address does not advance, but the flag schedule runs unchanged.
- R4: Array code 2'b00 targets the data array and 2'b01 targets the mask array. Codes 2'b10 and 2'b11 write nothing but still advance the address. dq_i[14:0] in the command clocks has no effect.
- R5: Words go to consecutive addresses starting at the burst register address, which advances by one per accepted word, modulo 2^15. The storage index is the low log2(depth) address bits. A following burst without reloading continues where the last one ended.
- R6: eot_oe_o is 1 in clocks 3 to n+2, and also in clock n+1 when n=1. eot_o is 1 only in clock n+1 and 0 in every other driven clock.
- R7: eot_oe_o is 0 in idle and in clocks 1A and 1B. It drops right after clock n+2, and a new command is accepted in the very next clock.
- R8: While a burst is in progress, command-valid pulses and burst register loads are ignored.
- R9: Loading the burst register with length 0 stores length 1.
- R10: After reset the block is idle with the flag released, and all global mask registers hold 0.
- R11: rd_data_o combinationally returns the stored word at index rd_addr_i of the mask array when rd_arr_i=1, otherwise of the data array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_id_i | input | 5 | This device's ID |
| cmd_valid_i | input | 1 | Command valid |
| cmd_i | input | 6 | [1:0] opcode, [2] group bit, [5:3] mask register index |
| dq_i | input | 68 | Command fields in 1A/1B, write data in data clocks |
| cfg_we_i | input | 1 | Load burst register |
| cfg_addr_i | input | 15 | Start address to load |
| cfg_len_i | input | 8 | Burst length to load |
| gmask_we_i | input | 1 | Load a global mask register |
| gmask_sel_i | input | 3 | Mask register to load |
| gmask_data_i | input | 68 | Mask value to load |
| rd_arr_i | input | 1 | Read array select, 1 = mask array |
| rd_addr_i | input | 6 | Read index |
| rd_data_o | output | 68 | Stored word at the read index |
| eot_o | output | 1 | End-of-transfer value |
| eot_oe_o | output | 1 | End-of-transfer output enable |

## Verification
The assertions assume that the burst register and the mask registers are not loaded in the same clock as a command's 1A. They also assume that mask registers are left alone while a burst runs, since a mid-burst mask change would alter the merge of later words. The stimulus loads all registers only in idle clocks between bursts. It deliberately injects command pulses and burst-register loads inside running bursts, because those must be ignored. Random bursts vary the ID among own, broadcast and foreign values, and vary the array code over all four values, the length over 0 to 9, and the mask index. Directed cases cover address wrap, continuation, the aborted 1B and masks left at their reset value.

// File: rtl/mbw_pkg.sv
package mbw_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CMDB, ST_RUN} seq_state_e;

  localparam logic [1:0] OP_BURST_WR = 2'b01;
  localparam logic [1:0] ARR_DATA    = 2'b00;
  localparam logic [1:0] ARR_MASK    = 2'b01;
  localparam int         CMD_GRP_BIT = 2;
  localparam int         CMD_GIDX_LSB = 3;
  localparam int         DQ_ID_LSB   = 21;
  localparam int         DQ_ARR_LSB  = 19;
endpackage

// File: rtl/mbw_cfg_reg.sv
module mbw_cfg_reg #(
  parameter int AW = 15,
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [LW-1:0] len_i,
  input  logic          busy_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o,
  output logic [LW-1:0] len_o
);
  logic [AW-1:0] addr_q;
  logic [LW-1:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      len_q  <= LW'(1);
    end else if (we_i && !busy_i) begin
      addr_q <= addr_i;
      len_q  <= (len_i == '0) ? LW'(1) : len_i;
    end else if (inc_i) begin
      addr_q <= addr_q + AW'(1);  // wraps mod 2^AW
    end
  end

  assign addr_o = addr_q;
  assign len_o  = len_q;
endmodule

// File: rtl/mbw_mask_bank.sv
module mbw_mask_bank #(
  parameter int DW = 68,
  parameter int MN = 8,
  localparam int GI_W = $clog2(MN)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [GI_W-1:0] wsel_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [GI_W-1:0] rsel_i,
  output logic [DW-1:0]   mask_o
);
  logic [DW-1:0] mask_q [MN];

  for (genvar g = 0; g < MN; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_q[g] <= '0;
      end else if (we_i && wsel_i == GI_W'(g)) begin
        mask_q[g] <= wdata_i;
      end
    end
  end

  assign mask_o = mask_q[rsel_i];
endmodule

// File: rtl/mbw_seq.sv
module mbw_seq
  import mbw_pkg::*;
#(
  parameter int LW   = 8,
  parameter int ID_W = 5,
  parameter int GI_W = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cmd_valid_i,
  input  logic [GI_W+2:0]       cmd_i,
  input  logic [ID_W-1:0]       dq_id_i,
  input  logic [1:0]            dq_arr_i,
  input  logic [ID_W-1:0]       dev_id_i,
  input  logic [LW-1:0]         len_i,
  output logic                  busy_o,
  output logic                  data_phase_o,
  output logic                  sel_o,
  output logic [1:0]            arr_o,
  output logic [GI_W-1:0]       gidx_o,
  output logic                  eot_o,
  output logic                  eot_oe_o
);
  localparam int CW = LW + 2;
  localparam logic [ID_W-1:0] ID_ALL = '1;

  seq_state_e      state_q;
  logic [CW-1:0]   cyc_q;
  logic [GI_W-1:0] gidx_q;
  logic [1:0]      arr_q;
  logic            sel_q;

  logic          wr_cmd;
  logic [CW-1:0] n_ext;
  logic          running;
  logic          last_cyc;

  assign wr_cmd   = cmd_valid_i && cmd_i[CMD_GRP_BIT] && (cmd_i[1:0] == OP_BURST_WR);
  assign n_ext    = CW'(len_i);
  assign running  = (state_q == ST_RUN);
  assign last_cyc = running && (cyc_q == n_ext + CW'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cyc_q   <= '0;
      gidx_q  <= '0;
      arr_q   <= '0;
      sel_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (wr_cmd) begin
            state_q <= ST_CMDB;
            gidx_q  <= cmd_i[GI_W+CMD_GIDX_LSB-1:CMD_GIDX_LSB];
            arr_q   <= dq_arr_i;
            sel_q   <= (dq_id_i == dev_id_i) || (dq_id_i == ID_ALL);
          end
        end
        ST_CMDB: begin
          if (wr_cmd) begin
            state_q <= ST_RUN;
            cyc_q   <= CW'(2);
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_RUN: begin
          if (last_cyc) begin
            state_q <= ST_IDLE;
            cyc_q   <= '0;
          end else begin
            cyc_q <= cyc_q + CW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign data_phase_o = running && (cyc_q <= n_ext + CW'(1));
  assign sel_o        = sel_q;
  assign arr_o        = arr_q;
  assign gidx_o       = gidx_q;
  assign eot_o        = running && (cyc_q == n_ext + CW'(1));
  assign eot_oe_o     = running && ((cyc_q >= CW'(3)) || eot_o);
endmodule

// File: rtl/mbw_array.sv
module mbw_array #(
  parameter int DW    = 68,
  parameter int DEPTH = 64,
  parameter int NARR  = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [1:0]       arr_sel_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DW-1:0]    wmask_i,
  input  logic             rd_sel_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [DW-1:0]    rd_data_o
);
  logic [DW-1:0] rd_vec [NARR];

  for (genvar g = 0; g < NARR; g++) begin : g_arr
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] merged;

    assign merged = (mem[idx_i] & ~wmask_i) | (wdata_i & wmask_i);

    always_ff @(posedge clk_i) begin
      if (we_i && arr_sel_i == 2'(g)) begin
        mem[idx_i] <= merged;
      end
    end

    assign rd_vec[g] = mem[rd_idx_i];
  end

  assign rd_data_o = rd_vec[rd_sel_i];
endmodule

// File: rtl/mbw_burst_write.sv
module mbw_burst_write
  import mbw_pkg::*;
#(
  parameter int DW    = 68,
  parameter int AW    = 15,
  parameter int LW    = 8,
  parameter int ID_W  = 5,
  parameter int MN    = 8,
  parameter int DEPTH = 64,
  localparam int GI_W  = $clog2(MN),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ID_W-1:0]  dev_id_i,
  input  logic             cmd_valid_i,
  input  logic [GI_W+2:0]  cmd_i,
  input  logic [DW-1:0]    dq_i,
  input  logic             cfg_we_i,
  input  logic [AW-1:0]    cfg_addr_i,
  input  logic [LW-1:0]    cfg_len_i,
  input  logic             gmask_we_i,
  input  logic [GI_W-1:0]  gmask_sel_i,
  input  logic [DW-1:0]    gmask_data_i,
  input  logic             rd_arr_i,
  input  logic [IDX_W-1:0] rd_addr_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             eot_o,
  output logic             eot_oe_o
);
  logic            busy;
  logic            data_phase;
  logic            sel_q;
  logic [1:0]      arr_q;
  logic [GI_W-1:0] gidx_q;
  logic [AW-1:0]   addr_q;
  logic [LW-1:0]   len_q;
  logic [DW-1:0]   cur_mask;
  logic            addr_inc;

  assign addr_inc = data_phase && sel_q;

  mbw_seq #(.LW(LW), .ID_W(ID_W), .GI_W(GI_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .dq_id_i     (dq_i[DQ_ID_LSB+ID_W-1:DQ_ID_LSB]),
    .dq_arr_i    (dq_i[DQ_ARR_LSB+1:DQ_ARR_LSB]),
    .dev_id_i    (dev_id_i),
    .len_i       (len_q),
    .busy_o      (busy),
    .data_phase_o(data_phase),
    .sel_o       (sel_q),
    .arr_o       (arr_q),
    .gidx_o      (gidx_q),
    .eot_o       (eot_o),
    .eot_oe_o    (eot_oe_o)
  );

  mbw_cfg_reg #(.AW(AW), .LW(LW)) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (cfg_we_i),
    .addr_i(cfg_addr_i),
    .len_i (cfg_len_i),
    .busy_i(busy),
    .inc_i (addr_inc),
    .addr_o(addr_q),
    .len_o (len_q)
  );

  mbw_mask_bank #(.DW(DW), .MN(MN)) u_masks (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (gmask_we_i),
    .wsel_i (gmask_sel_i),
    .wdata_i(gmask_data_i),
    .rsel_i (gidx_q),
    .mask_o (cur_mask)
  );

  mbw_array #(.DW(DW), .DEPTH(DEPTH), .NARR(2)) u_arr (
    .clk_i    (clk_i),
    .we_i     (addr_inc),
    .arr_sel_i(arr_q),
    .idx_i    (addr_q[IDX_W-1:0]),
    .wdata_i  (dq_i),
    .wmask_i  (cur_mask),
    .rd_sel_i (rd_arr_i),
    .rd_idx_i (rd_addr_i),
    .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/mbw_burst_write_chk.sv
module mbw_burst_write_chk #(
  parameter int AW = 15,
  parameter int LW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          eot_o,
  input logic          eot_oe_o,
  input logic          busy,
  input logic          addr_inc,
  input logic [AW-1:0] addr_q,
  input logic [LW-1:0] len_q
);
  assert_eot_only_when_driven_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eot_o |-> eot_oe_o);

  assert_eot_closing_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eot_o && eot_oe_o) |=> (eot_oe_o && !eot_o));

  assert_release_after_close_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eot_oe_o && !eot_o && $past(eot_o)) |=> !eot_oe_o);

  assert_no_drive_in_cmdb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !eot_oe_o);

  assert_addr_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_inc |=> (addr_q == $past(addr_q) + AW'(1)));

  assert_addr_hold_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !addr_inc) |=> (addr_q == $past(addr_q)));

  assert_len_nonzero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q != '0);
endmodule

bind mbw_burst_write mbw_burst_write_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .eot_o   (eot_o),
  .eot_oe_o(eot_oe_o),
  .busy    (busy),
  .addr_inc(addr_inc),
  .addr_q  (addr_q),
  .len_q   (len_q)
);

// File: tb/mbw_burst_write_test.sv
`timescale 1ns/1ps
module mbw_burst_write_test;
  localparam int DW = 68;
  localparam int DEPTH = 64;
  localparam logic [4:0] DEV = 5'd9;
  localparam logic [1:0] OP = 2'b01;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [5:0]    cmd = '0;
  logic [DW-1:0] dq = '0;
  logic          cfg_we = 1'b0;
  logic [14:0]   cfg_addr = '0;
  logic [7:0]    cfg_len = '0;
  logic          gm_we = 1'b0;
  logic [2:0]    gm_sel = '0;
  logic [DW-1:0] gm_data = '0;
  logic          rd_arr = 1'b0;
  logic [5:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          eot, eot_oe;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [DW-1:0] ref_mem [2][DEPTH];
  logic [DW-1:0] gm [8];
  logic [14:0]   m_addr;
  int            m_len;

  always #4 clk = ~clk;

  mbw_burst_write uut (
    .clk_i(clk), .rst_ni(rst_n), .dev_id_i(DEV), .cmd_valid_i(cmd_valid),
    .cmd_i(cmd), .dq_i(dq), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_len_i(cfg_len), .gmask_we_i(gm_we), .gmask_sel_i(gm_sel),
    .gmask_data_i(gm_data), .rd_arr_i(rd_arr), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .eot_o(eot), .eot_oe_o(eot_oe)
  );

  function automatic logic [DW-1:0] rnd_word();
    return DW'({$urandom, $urandom, $urandom});
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [DW-1:0] m);
    return (old & ~m) | (nw & m);
  endfunction

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic load_mask(int g, logic [DW-1:0] v);
    @(negedge clk);
    gm_we = 1'b1; gm_sel = 3'(g); gm_data = v;
    @(negedge clk);
    gm_we = 1'b0;
    gm[g] = v;
  endtask

  task automatic load_cfg(logic [14:0] a, int n);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_len = 8'(n);
    @(negedge clk);
    cfg_we = 1'b0;
    m_addr = a;
    m_len = (n == 0) ? 1 : n;
  endtask

  task automatic check_arrays(string req);
    for (int a = 0; a < 2; a++) begin
      for (int i = 0; i < DEPTH; i++) begin
        @(negedge clk);
        rd_arr = a[0]; rd_addr = 6'(i);
        #1;
        chk(rd_data === ref_mem[a][i], req, rd_data, ref_mem[a][i]);
      end
    end
  endtask

  task automatic burst(logic [4:0] id, logic [1:0] arr, int g, bit noise);
    logic [DW-1:0] w;
    bit sel;
    int n;
    n = m_len;
    sel = (id == DEV) || (id == 5'h1f);
    @(negedge clk);
    cfg_we = 1'b0;
    cmd_valid = 1'b1; cmd = {3'(g), 1'b1, OP};
    w = rnd_word(); w[25:21] = id; w[20:19] = arr; dq = w;
    #2;
    chk(eot_oe == 1'b0, "R7 idle at 1A", DW'(eot_oe), '0);
    @(negedge clk);
    cmd = {3'($urandom), 1'b1, OP};  // index change in 1B must be ignored (R1)
    w = rnd_word(); w[25:21] = id; w[20:19] = arr; dq = w;
    #2;
    chk(eot_oe == 1'b0, "R7 at 1B", DW'(eot_oe), '0);
    for (int c = 2; c <= n + 2; c++) begin
      @(negedge clk);
      cmd_valid = noise ? 1'($urandom) : 1'b0;  // R8 ignored while busy
      cmd = {3'($urandom), 1'b1, OP};
      cfg_we = noise && (c == 3) && (c <= n + 1);
      cfg_addr = 15'($urandom); cfg_len = 8'($urandom);
      w = rnd_word();
      dq = w;
      #2;
      chk(eot_oe == ((c >= 3) || (c == n + 1)), "R6 oe", DW'(eot_oe), DW'((c >= 3) || (c == n + 1)));
      chk(eot == (c == n + 1), "R6 eot", DW'(eot), DW'(c == n + 1));
      if (c <= n + 1 && sel) begin
        if (arr < 2) ref_mem[arr][m_addr[5:0]] = merge(ref_mem[arr][m_addr[5:0]], w, gm[g]);
        m_addr = m_addr + 15'd1;
      end
    end
    @(negedge clk);
    cmd_valid = 1'b0; cfg_we = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int g = 0; g < 8; g++) gm[g] = '0;
    m_addr = '0; m_len = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(eot_oe == 1'b0 && eot == 1'b0, "R10 reset flag", DW'({eot, eot_oe}), '0);
    rst_n = 1'b1;

    // fill both arrays through the all-ones mask (R2, R3 broadcast)
    load_mask(7, '1);
    load_cfg(15'd0, 64);
    burst(DEV, 2'b00, 7, 0);
    load_cfg(15'd0, 64);
    burst(5'h1f, 2'b01, 7, 0);
    check_arrays("R11 fill readback");

    // R10: mask register 3 still zero -> no change
    load_cfg(15'd10, 3);
    burst(DEV, 2'b00, 3, 0);
    check_arrays("R10 zero mask");

    // R2: partial mask
    load_mask(2, rnd_word());
    load_cfg(15'd5, 4);
    burst(DEV, 2'b01, 2, 0);
    check_arrays("R2 partial mask");

    // R9: length zero behaves as one
    load_cfg(15'd20, 0);
    burst(DEV, 2'b00, 7, 0);
    check_arrays("R9 zero length");

    // R5: wrap and continuation
    load_cfg(15'h7ffe, 5);
    burst(5'h1f, 2'b00, 7, 0);
    check_arrays("R5 wrap");
    burst(DEV, 2'b00, 7, 0);
    check_arrays("R5 continue");

    // R3: foreign ID writes nothing and keeps the address
    burst(DEV ^ 5'd1, 2'b00, 7, 0);
    check_arrays("R3 foreign id");
    burst(DEV, 2'b01, 7, 0);
    check_arrays("R3 resume after foreign");

    // R4: reserved array code writes nothing but steps the address
    burst(DEV, 2'b10, 7, 0);
    burst(DEV, 2'b00, 7, 0);
    check_arrays("R4 reserved code");

    // R1: 1B missing, and group bit clear
    @(negedge clk);
    cmd_valid = 1'b1; cmd = {3'd7, 1'b1, OP}; dq = '0; dq[25:21] = DEV;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd = {3'd7, 1'b0, OP}; dq = rnd_word(); dq[25:21] = DEV;
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      #2;
      chk(eot_oe == 1'b0, "R1 no burst started", DW'(eot_oe), '0);
    end
    check_arrays("R1 aborted command");
    burst(DEV, 2'b00, 7, 0);
    check_arrays("R1 after abort");

    // random bursts with in-burst noise (R8)
    for (int it = 0; it < 24; it++) begin
      int sel_id;
      logic [4:0] id;
      if ($urandom % 3 == 0) load_mask(int'($urandom % 8), rnd_word());
      if ($urandom % 2 == 0) load_cfg(15'($urandom), int'($urandom % 10));
      sel_id = int'($urandom % 4);
      id = (sel_id == 0) ? 5'h1f : (sel_id == 1) ? 5'($urandom) : DEV;
      burst(id, 2'($urandom), int'($urandom % 8), 1);
      check_arrays("R8 random burst");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule